// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the address-valid window and the read or write strobe of one programmed-I/O cycle on an IDE port, with every phase counted in bus clocks. A cycle has three timed phases: a setup phase with the address valid and no strobe, an active phase with the strobe asserted, and a hold phase with the address still valid after the strobe drops. A one-clock done pulse follows, and then the generator is idle again.

Each phase length comes from an 8-bit timing byte made of three packed fields. The fields map to clock counts through fixed tables that are not linear. A channel carries two such bytes. One is used for data-port accesses and the other for command and control accesses, and both drives on the channel share them. A request input selects which byte applies. The selected byte is decoded and captured when the request is accepted, so the cycle in flight keeps its timing if the byte changes. When ready-stretching is enabled, a device can hold the ready line low to lengthen the active phase.

Top module: `pio_cycle_gen`

## Requirements
- R1: After reset the generator is idle, and addr_valid, rd_strobe, wr_strobe, busy and done are all low.
- R2: Timing byte bits [7:6] set the setup phase. Codes 0, 1, 2 and 3 give 1, 2, 3 and 4 clocks of addr_valid before the strobe rises.
- R3: Timing byte bits [2:0] set the active phase. Codes 0 to 7 give 2, 3, 4, 5, 6, 8, 12 and 16 clocks of strobe.
- R4: Timing byte bits [5:3] set the hold phase. Codes 0 to 7 give 1, 2, 3, 4, 5, 6, 8 and 12 clocks of addr_valid after the strobe falls.
- R5: With sel_ctrl = 0 the cycle uses data_timing, and with sel_ctrl = 1 it uses ctrl_timing. The byte is captured when start is accepted, and later changes to it do not affect that cycle.
- R6: With is_write = 1 only wr_strobe pulses, and with is_write = 0 only rd_strobe pulses. The two strobes are never high together, and a strobe is only high while addr_valid is high.
- R7: The clock after the hold phase ends, done is high for exactly one clock. In the next clock busy is low.
- R8: A start is only accepted while busy is low. A start raised during a cycle does not begin another cycle.
- R9: When iordy_en = 1 and iordy is sampled low on the last clock of the active phase, the active phase and its strobe continue until iordy is sampled high. The strobe width becomes the larger of the table value and the clock on which iordy returns high.
- R10: When iordy_en = 0 the level on iordy has no effect on any phase length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one cycle (taken only when idle) |
| sel_ctrl | input | 1 | 0 = data-port access, 1 = command/control access |
| is_write | input | 1 | 1 = write strobe, 0 = read strobe |
| data_timing | input | 8 | Timing byte for data-port accesses |
| ctrl_timing | input | 8 | Timing byte for command/control accesses |
| iordy_en | input | 1 | Enable ready-stretching of the active phase |
| iordy | input | 1 | Device ready, sampled synchronously |
| addr_valid | output | 1 | High through setup, active and hold |
| rd_strobe | output | 1 | Read strobe during the active phase |
| wr_strobe | output | 1 | Write strobe during the active phase |
| busy | output | 1 | High from acceptance through the done clock |
| done | output | 1 | One-clock pulse at the end of a cycle |

## Verification
On every clock the assertions check that the strobes are exclusive and nested inside addr_valid, that the strobe never rises in the same clock as addr_valid, that done lasts one clock and is followed by idle, and that the last active clock waits on a low iordy only when stretching is enabled. Only the bench scenarios can show the exact phase lengths for each table code, the choice between the two timing bytes, the capture of the byte at acceptance, and that a start during a busy cycle is dropped. The bench measures setup, strobe and hold widths directly from the ports for every code and for random bytes.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int TBYTE_W = 8;
    localparam int MAX_CLKS = 16;
    localparam int CNT_W = $clog2(MAX_CLKS + 1);
    localparam int NUM_BYTES = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] hold;
    } phase_len_t;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act_len;
        logic [CNT_W-1:0] hold_len;
        logic             wr;
    } seq_state_t;

    function automatic logic [CNT_W-1:0] setup_clks(input logic [1:0] code);
        return CNT_W'(code) + CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] hold_clks(input logic [2:0] code);
        case (code)
            3'd6:    return CNT_W'(8);
            3'd7:    return CNT_W'(12);
            default: return CNT_W'(code) + CNT_W'(1);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] active_clks(input logic [2:0] code);
        case (code)
            3'd5:    return CNT_W'(8);
            3'd6:    return CNT_W'(12);
            3'd7:    return CNT_W'(16);
            default: return CNT_W'(code) + CNT_W'(2);
        endcase
    endfunction

endpackage

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
    import pio_pkg::*;
(
    input  logic [TBYTE_W-1:0] tbyte,
    output phase_len_t         len
);

    always_comb begin
        len.setup  = setup_clks(tbyte[7:6]);
        len.hold   = hold_clks(tbyte[5:3]);
        len.active = active_clks(tbyte[2:0]);
    end

    always_comb begin
        assert (len.setup != '0 && len.active > CNT_W'(1) && len.hold != '0
                && len.active <= CNT_W'(MAX_CLKS)); // R2 R3 R4
    end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_write,
    input  phase_len_t len_in,
    input  logic       iordy_en,
    input  logic       iordy,
    output logic       addr_valid,
    output logic       rd_strobe,
    output logic       wr_strobe,
    output logic       busy,
    output logic       done
);

    seq_state_t st_d, st_q;
    logic       last_cnt;
    logic       stall;

    assign last_cnt = (st_q.cnt == '0);
    assign stall    = iordy_en && !iordy;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase    = PH_SETUP;
                    st_d.cnt      = len_in.setup - CNT_W'(1);
                    st_d.act_len  = len_in.active;
                    st_d.hold_len = len_in.hold;
                    st_d.wr       = is_write;
                end
            end
            PH_SETUP: begin
                if (last_cnt) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.cnt   = st_q.act_len - CNT_W'(1);
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (last_cnt) begin
                    if (!stall) begin
                        st_d.phase = PH_HOLD;
                        st_d.cnt   = st_q.hold_len - CNT_W'(1);
                    end
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (last_cnt) begin
                    st_d.phase = PH_DONE;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_DONE: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, act_len: '0, hold_len: '0, wr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_valid = (st_q.phase == PH_SETUP) || (st_q.phase == PH_ACTIVE)
                     || (st_q.phase == PH_HOLD);
    assign rd_strobe  = (st_q.phase == PH_ACTIVE) && !st_q.wr;
    assign wr_strobe  = (st_q.phase == PH_ACTIVE) && st_q.wr;
    assign busy       = (st_q.phase != PH_IDLE);
    assign done       = (st_q.phase == PH_DONE);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe)); // R6
    AST_STROBE_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> addr_valid); // R6
    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> !(rd_strobe || wr_strobe)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy); // R8
    AST_IORDY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ACTIVE && last_cnt && iordy_en && !iordy)
        |=> (rd_strobe || wr_strobe)); // R9
    AST_IORDY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ACTIVE && last_cnt && !iordy_en)
        |=> (addr_valid && !rd_strobe && !wr_strobe)); // R10

endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen
    import pio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               sel_ctrl,
    input  logic               is_write,
    input  logic [TBYTE_W-1:0] data_timing,
    input  logic [TBYTE_W-1:0] ctrl_timing,
    input  logic               iordy_en,
    input  logic               iordy,
    output logic               addr_valid,
    output logic               rd_strobe,
    output logic               wr_strobe,
    output logic               busy,
    output logic               done
);

    logic [NUM_BYTES-1:0][TBYTE_W-1:0] tbytes;
    phase_len_t                        lens [NUM_BYTES];
    phase_len_t                        len_sel;

    assign tbytes[0] = data_timing;
    assign tbytes[1] = ctrl_timing;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_dec
        pio_timing_decode u_dec (
            .tbyte (tbytes[g]),
            .len   (lens[g])
        );
    end

    assign len_sel = sel_ctrl ? lens[1] : lens[0];

    pio_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_write   (is_write),
        .len_in     (len_sel),
        .iordy_en   (iordy_en),
        .iordy      (iordy),
        .addr_valid (addr_valid),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .busy       (busy),
        .done       (done)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!addr_valid && !rd_strobe && !wr_strobe && !done)); // R1

endmodule

// File: tb/tb_pio_cycle_gen.sv
module tb_pio_cycle_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       sel_ctrl = 1'b0;
    logic       is_write = 1'b0;
    logic [7:0] data_timing = 8'hF5;
    logic [7:0] ctrl_timing = 8'hDE;
    logic       iordy_en = 1'b0;
    logic       iordy = 1'b1;
    logic       addr_valid, rd_strobe, wr_strobe, busy, done;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pio_cycle_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_ctrl(sel_ctrl),
        .is_write(is_write), .data_timing(data_timing), .ctrl_timing(ctrl_timing),
        .iordy_en(iordy_en), .iordy(iordy), .addr_valid(addr_valid),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .busy(busy), .done(done)
    );

    function automatic int exp_setup(input logic [7:0] b);
        return int'(b[7:6]) + 1;
    endfunction

    function automatic int exp_hold(input logic [7:0] b);
        int t [8] = '{1, 2, 3, 4, 5, 6, 8, 12};
        return t[b[5:3]];
    endfunction

    function automatic int exp_active(input logic [7:0] b);
        int t [8] = '{2, 3, 4, 5, 6, 8, 12, 16};
        return t[b[2:0]];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one cycle and measures each phase at the ports.
    // stretch_to > 0 holds iordy low until that many strobe clocks.
    // poke raises start during the cycle; mutate changes the selected byte mid-cycle.
    task automatic run_cycle(input logic ctrl, input logic wr, input logic en,
                             input logic iordy_low, input int stretch_to,
                             input logic poke, input logic mutate,
                             output int s, output int a, output int h,
                             output int dn, output int bad_dir, output int idle_after);
        @(negedge clk);
        sel_ctrl = ctrl; is_write = wr; iordy_en = en;
        iordy = !iordy_low; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        s = 0; a = 0; h = 0; dn = 0; bad_dir = 0; idle_after = 1;
        for (int k = 0; k < 200; k++) begin
            if (done) begin
                dn = 1;
                break;
            end
            if (rd_strobe || wr_strobe) begin
                a++;
                if (wr ? (rd_strobe || !wr_strobe) : (wr_strobe || !rd_strobe)) bad_dir++;
                if (!addr_valid) bad_dir++;
                if (iordy_low && a >= stretch_to) iordy = 1'b1;
                if (poke && a == 1) start = 1'b1;
                if (mutate && a == 1) begin
                    data_timing = ~data_timing;
                    ctrl_timing = ~ctrl_timing;
                end
            end else begin
                start = 1'b0;
                if (addr_valid) begin
                    if (a == 0) s++;
                    else h++;
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        iordy = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (busy || done || addr_valid) idle_after = 0;
        end
    endtask

    task automatic do_cycle(input logic [7:0] dbyte, input logic [7:0] cbyte,
                            input logic ctrl, input logic wr, input logic en,
                            input logic iordy_low, input int extra,
                            input logic poke, input logic mutate);
        logic [7:0] eb;
        int s, a, h, dn, bd, ia, ea;
        data_timing = dbyte;
        ctrl_timing = cbyte;
        eb = ctrl ? cbyte : dbyte;
        ea = exp_active(eb);
        run_cycle(ctrl, wr, en, iordy_low, ea + extra, poke, mutate, s, a, h, dn, bd, ia);
        check("R2 setup clocks", s, exp_setup(eb));
        if (en && iordy_low) check("R9 stretched strobe", a, ea + extra);
        else if (iordy_low) check("R10 iordy ignored strobe", a, ea);
        else if (mutate) check("R5 byte captured strobe", a, ea);
        else check("R3 strobe clocks", a, ea);
        check("R4 hold clocks", h, exp_hold(eb));
        check("R7 done pulse seen", dn, 1);
        check("R6 strobe direction", bd, 0);
        if (poke) check("R8 start during busy dropped", ia, 1);
        else check("R7 idle after done", ia, 1);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 quiet after reset", {addr_valid, rd_strobe, wr_strobe, busy, done}, 0);

        // R2 R3 R4 sweep every field code
        for (int c = 0; c < 8; c++) begin
            do_cycle({2'(c % 4), 3'(c), 3'(c)}, 8'h00, 1'b0, c[0], 1'b0, 1'b0, 0, 1'b0, 1'b0);
        end
        // data-byte values for slow and fast transfer modes
        do_cycle(8'hF5, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        do_cycle(8'h09, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        do_cycle(8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        // R5 command/control byte chosen over data byte
        do_cycle(8'h00, 8'hDE, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        do_cycle(8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        // R5 byte changed mid-cycle
        do_cycle(8'h4A, 8'h4A, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b1);
        // R9 stretch by a few clocks, R10 low iordy with stretching off
        do_cycle(8'h12, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 5, 1'b0, 1'b0);
        do_cycle(8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1, 1'b0, 1'b0);
        do_cycle(8'h12, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5, 1'b0, 1'b0);
        // R8 start pulsed while busy
        do_cycle(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b1, 1'b0);

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [7:0] db, cb;
            logic ct, w, en, lo;
            int ex;
            db = 8'($urandom); cb = 8'($urandom);
            ct = 1'($urandom); w = 1'($urandom);
            en = 1'($urandom); lo = 1'($urandom);
            ex = int'($urandom % 6);
            do_cycle(db, cb, ct, w, en, lo, ex, 1'b0, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule